// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small controller system. After reset it is inactive. Software arms it by writing a two-byte unlock key to a restart register. Repeating the same key later restarts the count. Once armed, nothing but a reset or its own time-out can disarm it. A program register holds two settings: a 3-bit time-out selector, and a rate bit that, together with the core clock mode, decides whether the count advances on every oscillator cycle or on every second one. When the count reaches its limit, the block drives an active-low system reset for a fixed number of oscillator cycles. That pulse also returns the watchdog to its reset state.

The count freezes while the system is in power-down. It stays frozen after the power-down request drops, until a wake strobe reports that an interrupt ended the power-down. It then resumes from the held value. While the CPU is merely idle the count keeps running, because nothing in the block depends on idle. The write port is a plain strobe with no back-pressure: every write is taken in the cycle it is presented.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low and after it rises, `wdt_rst_n` is high and no reset pulse is produced until the watchdog has been armed.
- R2: A write of 8'h1E and then a write of 8'hE1 to the restart register (`wr_addr`=0) arms the watchdog at the clock edge that captures the 8'hE1 write. The first reset pulse then starts exactly BASE_MULT·2^BASE_SHIFT·2^SEL watchdog ticks after that edge.
- R3: Repeating the key while armed clears the count. The next pulse comes a full time-out after the edge that captures the new 8'hE1.
- R4: Once the watchdog is armed, no write to either register disarms it or delays the pending pulse, unless the write completes the key.
- R5: The key detector only watches restart-register writes. After an 8'h1E, any restart write other than 8'hE1 (including a second 8'h1E) returns it to idle. An 8'hE1 without a preceding 8'h1E does nothing. Program-register writes between the two key bytes do not disturb the sequence.
- R6: SEL is program-register (`wr_addr`=1) bits [2:0]. The limit is latched at each arm or restart, so a SEL change while armed takes effect only at the next restart.
- R7: A tick occurs on every oscillator cycle when `x2_mode`=1 and program bit 3 is 0. Otherwise a tick occurs on every second cycle, starting with the second cycle after the arm or restart edge.
- R8: On overflow, `wdt_rst_n` goes low at the edge where the last tick lands and stays low for exactly PULSE_LEN (96) cycles.
- R9: The pulse disarms the watchdog and clears the program register to 0. Writes made during the pulse are ignored. Afterwards no further pulse occurs until the watchdog is armed again.
- R10: Every edge at which `pdown` is high, or at which a power-down is still latched (from a `pdown` rise until the edge that samples `wake` high, inclusive), adds no tick. Counting then continues from the held value.
- R11: A reset applied during power-down leaves the watchdog disarmed, with no pulse afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = restart/key register, 1 = program register |
| wr_data | input | 8 | Write data |
| x2_mode | input | 1 | Core runs in double-speed clock mode |
| pdown | input | 1 | Power-down in effect |
| wake | input | 1 | Strobe: interrupt has ended power-down |
| wdt_rst_n | output | 1 | Watchdog reset output, active low |

## Verification
A key write's effect lands at the clock edge that captures the 8'hE1 byte. The first low output is due D edges later, where D is the limit in ticks, doubled in divided-rate mode, plus one edge for each frozen power-down edge. The output then stays low for 96 edges. The bench numbers rising edges with its own counter and samples on falling edges. It computes the exact edge number of every expected fall and rise, and flags a low sample before that edge as early and a high sample at it as late. Quiet periods after ignored stimulus are sampled on every falling edge for hundreds of cycles.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;
  localparam int unsigned KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 8'h1E;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 8'hE1;
  localparam logic ADDR_RESTART = 1'b0;
  localparam logic ADDR_PROGRAM = 1'b1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_key_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  output logic             kick
);
  seq_state_e st_q, st_d;
  logic       rs_wr;

  assign rs_wr = wr_en && (wr_addr == ADDR_RESTART) && !clr;

  always_comb begin
    st_d = st_q;
    kick = 1'b0;
    if (rs_wr) begin
      if (st_q == SEQ_HALF && wr_data == KEY_CLOSE) begin
        kick = 1'b1;
        st_d = SEQ_IDLE;
      end else if (st_q == SEQ_IDLE && wr_data == KEY_OPEN) begin
        st_d = SEQ_HALF;
      end else begin
        st_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEQ_IDLE;
    else if (clr) st_q <= SEQ_IDLE;
    else          st_q <= st_d;
  end

  // R5
  kick_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);

  // R9
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic fast,
  output logic tick
);
  localparam int unsigned DW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);

  logic [DW-1:0] ph_q;

  assign tick = run && (fast || ph_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ph_q <= '0;
    else if (restart)       ph_q <= '0;
    else if (run && !fast)  ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  // R7
  slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast && run) |=> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_MULT  = 6,
  parameter int unsigned BASE_SHIFT = 14,
  parameter int unsigned TO_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kick,
  input  logic            clr,
  input  logic            hold,
  input  logic            tick,
  input  logic [TO_W-1:0] to_sel,
  output logic            armed,
  output logic            fire
);
  localparam int unsigned MAX_SHIFT = BASE_SHIFT + (1 << TO_W) - 1;
  localparam int unsigned CW = $clog2(BASE_MULT + 1) + MAX_SHIFT + 1;

  logic          armed_q;
  logic [CW-1:0] cnt_q, term_q, term_next;

  assign term_next = CW'(BASE_MULT) << (BASE_SHIFT + int'(to_sel));
  assign fire      = armed_q && tick && !hold && (cnt_q == term_q - CW'(1));
  assign armed     = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      term_q  <= '0;
    end else if (clr || fire) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (kick) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      term_q  <= term_next;
    end else if (armed_q && tick && !hold) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  sticky_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !fire && !clr) |=> armed_q);

  // R2
  below_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q < term_q));

  // R10
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !kick && !clr) |=> $stable(cnt_q));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !kick) |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic rst_out_n
);
  localparam int unsigned PW = $clog2(PULSE_LEN);
  localparam logic [PW-1:0] PEND = PW'(PULSE_LEN - 1);

  logic          act_q;
  logic [PW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pc_q  <= '0;
    end else if (act_q) begin
      if (pc_q == PEND) begin
        act_q <= 1'b0;
        pc_q  <= '0;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end else if (fire) begin
      act_q <= 1'b1;
      pc_q  <= '0;
    end
  end

  assign active    = act_q;
  assign rst_out_n = ~act_q;

  // R8
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(fire));

  // R8
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && pc_q != PEND) |=> act_q);

  // R8
  end_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(pc_q) == PEND));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_key_pkg::*;
#(
  parameter int unsigned BASE_MULT  = 6,
  parameter int unsigned BASE_SHIFT = 14,
  parameter int unsigned TO_W       = 3,
  parameter int unsigned SLOW_DIV   = 2,
  parameter int unsigned PULSE_LEN  = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             x2_mode,
  input  logic             pdown,
  input  logic             wake,
  output logic             wdt_rst_n
);
  localparam int unsigned PRG_W = TO_W + 1;

  logic             kick, fire, armed, tick, pulse_act, hold, fast;
  logic             frz_q;
  logic [PRG_W-1:0] prog_q;

  // program register: [TO_W-1:0] time-out select, [TO_W] halve-rate bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prog_q <= '0;
    else if (pulse_act) prog_q <= '0;
    else if (wr_en && wr_addr == ADDR_PROGRAM)
      prog_q <= wr_data[PRG_W-1:0];
  end

  // power-down latch: held from pdown until a wake strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frz_q <= 1'b0;
    else if (pdown) frz_q <= 1'b1;
    else if (wake)  frz_q <= 1'b0;
  end

  assign hold = pdown || frz_q;
  assign fast = x2_mode && !prog_q[TO_W];

  wdt_keyseq u_keyseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pulse_act),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .kick    (kick)
  );

  wdt_prescale #(.SLOW_DIV(SLOW_DIV)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (armed && !hold),
    .restart (kick),
    .fast    (fast),
    .tick    (tick)
  );

  wdt_counter #(
    .BASE_MULT  (BASE_MULT),
    .BASE_SHIFT (BASE_SHIFT),
    .TO_W       (TO_W)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (kick),
    .clr    (pulse_act),
    .hold   (hold),
    .tick   (tick),
    .to_sel (prog_q[TO_W-1:0]),
    .armed  (armed),
    .fire   (fire)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .active    (pulse_act),
    .rst_out_n (wdt_rst_n)
  );

  // R9
  pulse_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_act |-> !armed);

  // R9
  pulse_prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_act |=> (prog_q == '0));

  // R10
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !wake) |=> frz_q);
endmodule

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
  localparam int BM = 6, BS = 1, PL = 96;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       x2_mode = 1'b0, pdown = 1'b0, wake = 1'b0;
  logic       wdt_rst_n;
  int         checks = 0, fails = 0, cyc = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_watchdog #(.BASE_MULT(BM), .BASE_SHIFT(BS), .TO_W(3),
                   .SLOW_DIV(2), .PULSE_LEN(PL)) i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .x2_mode(x2_mode), .pdown(pdown), .wake(wake),
    .wdt_rst_n(wdt_rst_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic arm();
    wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
  endtask

  function automatic int period(input int sel, input bit x2, input bit halve);
    int t = (BM << BS) << sel;
    return (x2 && !halve) ? t : 2 * t;
  endfunction

  task automatic expect_fire(input int fire_cyc, input string req);
    int early = -1;
    while (cyc < fire_cyc) begin
      @(negedge clk);
      if (cyc < fire_cyc && !wdt_rst_n && early < 0) early = cyc;
    end
    chk(early < 0 && !wdt_rst_n, req, (early < 0) ? (wdt_rst_n ? -1 : cyc) : early, fire_cyc);
  endtask

  task automatic expect_pulse(input string req);
    int lows = wdt_rst_n ? 0 : 1;
    while (lows > 0 && lows <= PL + 5) begin
      @(negedge clk);
      if (wdt_rst_n) break;
      lows++;
    end
    chk(lows == PL, req, lows, PL);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!wdt_rst_n) lows++;
    end
    chk(lows == 0, req, lows, 0);
  endtask

  initial begin
    int e0;
    repeat (4) @(negedge clk);
    chk(wdt_rst_n === 1'b1, "R1", int'(wdt_rst_n), 1);
    rst_n = 1'b1;
    expect_quiet(300, "R1");

    // sweep: rate modes x all selector values
    for (int m = 0; m < 3; m++) begin
      bit hv = (m == 1);
      x2_mode = (m != 0);
      for (int s = 0; s < 8; s++) begin
        wr(1'b1, {4'h0, hv, 3'(s)});
        arm(); e0 = cyc;
        expect_fire(e0 + period(s, x2_mode, hv), "R2 R6 R7");
        expect_pulse("R8");
      end
    end

    // R9: disarmed and program cleared after the pulse
    expect_quiet(2000, "R9");
    arm(); e0 = cyc;
    expect_fire(e0 + period(0, 1'b1, 1'b0), "R9");
    expect_pulse("R8");

    // R3: restart clears the count
    wr(1'b1, 8'h02);
    arm();
    repeat (20) @(negedge clk);
    arm(); e0 = cyc;
    expect_fire(e0 + period(2, 1'b1, 1'b0), "R3");
    expect_pulse("R8");

    // R4 R6: stray writes neither disarm nor re-time
    wr(1'b1, 8'h02);
    arm(); e0 = cyc;
    wr(1'b1, 8'h00); wr(1'b0, 8'h00); wr(1'b0, 8'h1E); wr(1'b0, 8'h55); wr(1'b0, 8'hE1);
    expect_fire(e0 + period(2, 1'b1, 1'b0), "R4 R6");
    expect_pulse("R8");

    // R5: sequence detector rules
    wr(1'b0, 8'hE1);
    expect_quiet(200, "R5");
    wr(1'b0, 8'h1E); wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
    expect_quiet(200, "R5");
    wr(1'b0, 8'h1E); wr(1'b1, 8'h01); wr(1'b0, 8'hE1); e0 = cyc;
    expect_fire(e0 + period(1, 1'b1, 1'b0), "R5");
    expect_pulse("R8");

    // R10: freeze and resume, 11 frozen edges
    arm(); e0 = cyc;
    repeat (3) @(negedge clk);
    pdown = 1'b1; repeat (6) @(negedge clk);
    pdown = 1'b0; repeat (4) @(negedge clk);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    expect_fire(e0 + period(0, 1'b1, 1'b0) + 11, "R10");
    expect_pulse("R8");

    // R10: stays frozen without wake, 102 frozen edges
    arm(); e0 = cyc;
    pdown = 1'b1; @(negedge clk); pdown = 1'b0;
    expect_quiet(100, "R10");
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    expect_fire(e0 + period(0, 1'b1, 1'b0) + 102, "R10");
    expect_pulse("R8");

    // R11: reset during power-down disarms
    arm();
    repeat (3) @(negedge clk);
    pdown = 1'b1; @(negedge clk);
    rst_n = 1'b0; repeat (3) @(negedge clk);
    chk(wdt_rst_n === 1'b1, "R11", int'(wdt_rst_n), 1);
    rst_n = 1'b1; pdown = 1'b0; wake = 1'b1; @(negedge clk); wake = 1'b0;
    expect_quiet(300, "R11");
    arm(); e0 = cyc;
    expect_fire(e0 + period(0, 1'b1, 1'b0), "R1 R2");
    expect_pulse("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule